// File: doc/BRIEF.md
# Input Pulse Interval Capture Timer

This block is one timer channel that measures the time between qualifying edges on an input pin. It has an up-counter that advances once for each cycle on which a count-clock enable (`tick`) is high. Each qualifying edge stores the running count in a capture register, clears the counter and raises an interrupt pulse. A status flag reports whether the counter wrapped during the interval just measured. It is set or cleared again at every capture.

Software drives the channel through a simple write port and a registered read port. Writing to a trigger register starts or stops the channel, and the trigger bits do not persist. A mode register selects the edge polarity, enables an optional interrupt at start, and carries a 4-bit auxiliary control field. While the channel runs, only the edge polarity can be changed. A unit-level enable held low keeps the whole channel in its default state.

Top module: `pulse_interval_timer`

## Requirements
- R1: After reset, every readable register reads 0 and `irq` is low. Address map: 0 = counter, 1 = capture, 2 = status (bit 0 = overflow), 3 = mode, 4 = trigger, 5 = enable status (bit 0). Read data appears one clock after `rd_addr` is presented.
- R2: Writing address 4 with bit 0 = 1 and bit 1 = 0 sets the enable status to 1. Address 4 always reads 0.
- R3: On the first `tick` after a start, the counter is loaded with 0. If mode bit 2 (start-interrupt) is 1, `irq` pulses at that point. If it is 0, there is no pulse.
- R4: While running, a qualifying edge seen on a `tick` cycle does three things in one cycle: it copies the count into the capture register, clears the counter, and pulses `irq` high for exactly one cycle. Each pin change reaches the edge logic after a two-flop synchronizer, so an interval of D cycles captures D-1.
- R5: Mode bits [1:0] select the qualifying edge: 00 = falling, 01 = rising, 10 = both, 11 = falling. Other edges are ignored.
- R6: At each capture, status bit 0 becomes 1 if the counter wrapped from FFFFh to 0 since the last capture or start. Otherwise it becomes 0. The flag changes at no other time.
- R7: Writing address 4 with bit 1 = 1 clears the enable status, and this takes priority over a start bit in the same write. When stopped, the counter holds its value, the overflow flag is kept, and no interrupts occur.
- R8: When stopped, mode bits [1:0], bit 2 and bits [7:4] are all writable. While running, only bits [1:0] change, and writes to the other fields are ignored.
- R9: While `unit_en` is 0, every register is held at its default value and writes are ignored.
- R10: The counter advances only on `tick` cycles, and pin edges are sampled only on `tick` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| unit_en | input | 1 | Unit-level enable; 0 holds the channel in its default state |
| tick | input | 1 | Count-clock enable |
| pin_in | input | 1 | Measured input pin (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | CNT_W | Registered read data |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The two behaviours that can land on the same clock are the start and stop triggers. A single write with both bits set puts them in the same cycle. The bench does this while the channel runs, then checks that the enable status reads 0 and that no start interrupt follows. A second collision can happen at the load tick, where a capture edge could arrive together with the start load. The bench keeps its first edge several cycles clear of the load. It then judges the load result through the first captured value, which must equal the elapsed cycles plus one.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int PIT_AW = 3;

  localparam logic [PIT_AW-1:0] A_COUNT = 3'd0;
  localparam logic [PIT_AW-1:0] A_CAPT  = 3'd1;
  localparam logic [PIT_AW-1:0] A_STAT  = 3'd2;
  localparam logic [PIT_AW-1:0] A_MODE  = 3'd3;
  localparam logic [PIT_AW-1:0] A_TRIG  = 3'd4;
  localparam logic [PIT_AW-1:0] A_EN    = 3'd5;

  localparam int TRIG_START = 0;
  localparam int TRIG_STOP  = 1;
  localparam int SIRQ_BIT   = 2;
  localparam int AUX_LSB    = 4;
  localparam int AUX_W      = 4;

  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_RSVD = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/pit_edge_detect.sv
module pit_edge_detect
  import pit_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      clr,
  input  logic      tick,
  input  logic      pin_in,
  input  edge_sel_e edge_sel,
  output logic      edge_hit
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   cur;
  logic                   rise;
  logic                   fall;

  assign cur = sync_q[SYNC_STAGES-1];

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk) begin
        if (clr) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (clr) sync_q <= '0;
        else     sync_q <= pin_in;
      end
    end
  endgenerate

  // last level seen on a count-clock cycle
  always_ff @(posedge clk) begin
    if (clr)       prev_q <= 1'b0;
    else if (tick) prev_q <= cur;
  end

  assign rise = cur & ~prev_q;
  assign fall = ~cur & prev_q;

  always_comb begin
    unique case (edge_sel)
      EDGE_RISE: edge_hit = tick & rise;
      EDGE_BOTH: edge_hit = tick & (rise | fall);
      default:   edge_hit = tick & fall;
    endcase
  end
endmodule

// File: rtl/pit_capture_counter.sv
module pit_capture_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             tick,
  input  logic             run,
  input  logic             edge_hit,
  input  logic             start_evt,
  input  logic             stop_evt,
  input  logic             start_irq_en,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] capt_q,
  output logic             ovf_q,
  output logic             pend_q,
  output logic             irq_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic wrap_seen_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      count_q     <= '0;
      capt_q      <= '0;
      ovf_q       <= 1'b0;
      pend_q      <= 1'b0;
      wrap_seen_q <= 1'b0;
      irq_q       <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (run && tick) begin
        if (pend_q) begin
          count_q     <= '0;
          wrap_seen_q <= 1'b0;
          pend_q      <= 1'b0;
          irq_q       <= start_irq_en;
        end else if (edge_hit) begin
          capt_q      <= count_q;
          ovf_q       <= wrap_seen_q;
          count_q     <= '0;
          wrap_seen_q <= 1'b0;
          irq_q       <= 1'b1;
        end else begin
          count_q <= count_q + 1'b1;
          if (count_q == CNT_MAX) wrap_seen_q <= 1'b1;
        end
      end
      if (start_evt) pend_q <= 1'b1;
      if (stop_evt)  pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pit_ctrl_regs.sv
module pit_ctrl_regs
  import pit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [PIT_AW-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [PIT_AW-1:0] rd_addr,
  input  logic [CNT_W-1:0]  count,
  input  logic [CNT_W-1:0]  capt,
  input  logic              ovf,
  output logic [CNT_W-1:0]  rd_data,
  output logic              run_q,
  output logic              start_evt,
  output logic              stop_evt,
  output edge_sel_e         edge_sel,
  output logic              start_irq_en,
  output logic [AUX_W-1:0]  aux_q
);
  logic             wr_ok;
  logic [CNT_W-1:0] mode_word;
  logic [CNT_W-1:0] rd_next;
  logic             unused_hi;

  assign wr_ok     = wr_en & ~clr;
  assign start_evt = wr_ok && (wr_addr == A_TRIG) && wr_data[TRIG_START] && !wr_data[TRIG_STOP];
  assign stop_evt  = wr_ok && (wr_addr == A_TRIG) && wr_data[TRIG_STOP];
  assign unused_hi = ^wr_data[CNT_W-1:AUX_LSB+AUX_W] ^ wr_data[3];

  always_ff @(posedge clk) begin
    if (clr) begin
      run_q        <= 1'b0;
      edge_sel     <= EDGE_FALL;
      start_irq_en <= 1'b0;
      aux_q        <= '0;
    end else begin
      if (stop_evt)       run_q <= 1'b0;
      else if (start_evt) run_q <= 1'b1;
      if (wr_ok && wr_addr == A_MODE) begin
        edge_sel <= edge_sel_e'(wr_data[1:0]);
        if (!run_q) begin
          start_irq_en <= wr_data[SIRQ_BIT];
          aux_q        <= wr_data[AUX_LSB +: AUX_W];
        end
      end
    end
  end

  always_comb begin
    mode_word                    = '0;
    mode_word[1:0]               = edge_sel;
    mode_word[SIRQ_BIT]          = start_irq_en;
    mode_word[AUX_LSB +: AUX_W]  = aux_q;
  end

  always_comb begin
    unique case (rd_addr)
      A_COUNT: rd_next = count;
      A_CAPT:  rd_next = capt;
      A_STAT:  rd_next = {{(CNT_W-1){1'b0}}, ovf};
      A_MODE:  rd_next = mode_word;
      A_EN:    rd_next = {{(CNT_W-1){1'b0}}, run_q};
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end
endmodule

// File: rtl/pulse_interval_timer.sv
module pulse_interval_timer
  import pit_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              unit_en,
  input  logic              tick,
  input  logic              pin_in,
  input  logic              wr_en,
  input  logic [PIT_AW-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [PIT_AW-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic              irq
);
  logic             clr;
  logic             run;
  logic             start_evt;
  logic             stop_evt;
  edge_sel_e        edge_sel;
  logic             start_irq_en;
  logic [AUX_W-1:0] aux;
  logic             edge_hit;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] capt;
  logic             ovf;
  logic             pend;

  assign clr = rst | ~unit_en;

  pit_ctrl_regs #(.CNT_W(CNT_W)) u_regs (
    .clk          (clk),
    .rst          (rst),
    .clr          (clr),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .rd_addr      (rd_addr),
    .count        (count),
    .capt         (capt),
    .ovf          (ovf),
    .rd_data      (rd_data),
    .run_q        (run),
    .start_evt    (start_evt),
    .stop_evt     (stop_evt),
    .edge_sel     (edge_sel),
    .start_irq_en (start_irq_en),
    .aux_q        (aux)
  );

  pit_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .clr      (clr),
    .tick     (tick),
    .pin_in   (pin_in),
    .edge_sel (edge_sel),
    .edge_hit (edge_hit)
  );

  pit_capture_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk          (clk),
    .clr          (clr),
    .tick         (tick),
    .run          (run),
    .edge_hit     (edge_hit),
    .start_evt    (start_evt),
    .stop_evt     (stop_evt),
    .start_irq_en (start_irq_en),
    .count_q      (count),
    .capt_q       (capt),
    .ovf_q        (ovf),
    .pend_q       (pend),
    .irq_q        (irq)
  );
endmodule

// File: rtl/pit_checker.sv
module pit_checker
  import pit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              unit_en,
  input logic              tick,
  input logic              wr_en,
  input logic [PIT_AW-1:0] wr_addr,
  input logic [1:0]        trig_bits,
  input logic              run,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  capt,
  input logic              ovf,
  input logic              pend,
  input logic              edge_hit,
  input logic [AUX_W-1:0]  aux,
  input logic              irq
);
  logic cap_now;
  logic trig_wr;
  assign cap_now = unit_en && run && tick && edge_hit && !pend;
  assign trig_wr = unit_en && wr_en && (wr_addr == A_TRIG);

  // R4
  capture_clear_chk: assert property (@(posedge clk) disable iff (rst)
    cap_now |=> (capt == $past(count)) && (count == '0) && irq);

  // R10
  tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (unit_en && !tick) |=> $stable(count));

  // R2
  start_run_chk: assert property (@(posedge clk) disable iff (rst)
    (trig_wr && trig_bits[TRIG_START] && !trig_bits[TRIG_STOP]) |=> run);

  // R7
  stop_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (trig_wr && trig_bits[TRIG_STOP]) |=> !run);

  // R8
  mode_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (unit_en && run) |=> $stable(aux));

  // R9
  unit_off_chk: assert property (@(posedge clk) disable iff (rst)
    !unit_en |=> (!run && count == '0 && capt == '0 && !irq));

  // R6
  ovf_only_at_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (unit_en && !cap_now) |=> $stable(ovf));
endmodule

bind pulse_interval_timer pit_checker #(.CNT_W(CNT_W)) u_pit_checker (
  .clk       (clk),
  .rst       (rst),
  .unit_en   (unit_en),
  .tick      (tick),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .trig_bits (wr_data[1:0]),
  .run       (run),
  .count     (count),
  .capt      (capt),
  .ovf       (ovf),
  .pend      (pend),
  .edge_hit  (edge_hit),
  .aux       (aux),
  .irq       (irq)
);

// File: tb/pulse_interval_timer_test.sv
module pulse_interval_timer_test;
  import pit_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  typedef struct packed {
    logic         is_start;
    logic [W-1:0] val;
    logic         ovf;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst, unit_en, tick, pin_in, wr_en;
  logic [2:0]    wr_addr, rd_addr;
  logic [W-1:0]  wr_data, rd_data;
  logic          irq;

  int     errors = 0;
  int     checks = 0;
  int     irq_cnt = 0;
  bit     done = 0;
  longint cyc = 0;
  longint anchor = 0;
  exp_t   q[$];

  pulse_interval_timer uut (
    .clk(clk), .rst(rst), .unit_en(unit_en), .tick(tick), .pin_in(pin_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [W-1:0] exp);
    logic [W-1:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  // driver: sets the pin and pushes the expected capture into the scoreboard
  task automatic pin_at(input int n, input logic v, input bit cap);
    longint d;
    repeat (n) @(negedge clk);
    pin_in = v;
    if (cap) begin
      d = cyc - anchor - 1;
      q.push_back('{1'b0, d[W-1:0], (d > 65535)});
      anchor = cyc;
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  // monitor: pops expected items whenever the interrupt pulses
  initial begin
    exp_t it;
    logic [W-1:0] v;
    forever begin
      @(negedge clk);
      if (irq === 1'b1) begin
        irq_cnt++;
        if (q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R4: unexpected irq actual=1 expected=0");
        end else begin
          it = q.pop_front();
          if (!it.is_start) rd_addr = A_CAPT;
          @(negedge clk);
          check(it.is_start ? "R3 start pulse width" : "R4 pulse width", {15'd0, irq}, 16'd0);
          if (!it.is_start) begin
            v = rd_data;
            rd_addr = A_STAT;
            @(negedge clk);
            check("R4 captured value", v, it.val);
            check("R6 overflow flag", rd_data, {15'd0, it.ovf});
          end
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] c1, c2;
    int n;
    rst = 1'b1; unit_en = 1'b1; tick = 1'b1; pin_in = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 defaults
    check("R1 irq", {15'd0, irq}, 16'd0);
    rd_chk("R1 count", A_COUNT, 16'h0);
    rd_chk("R1 capture", A_CAPT, 16'h0);
    rd_chk("R1 status", A_STAT, 16'h0);
    rd_chk("R1 mode", A_MODE, 16'h0);
    rd_chk("R1 enable", A_EN, 16'h0);

    // R8 all fields writable when stopped: rising, start irq on, aux=A
    wr(A_MODE, 16'h00A5);
    rd_chk("R8 mode stopped", A_MODE, 16'h00A5);

    // R2 / R3 start with start interrupt
    q.push_back('{1'b1, 16'h0, 1'b0});
    wr(A_TRIG, 16'h0001);
    anchor = cyc - 2;
    rd_chk("R2 enable set", A_EN, 16'h0001);
    rd_chk("R2 trigger reads 0", A_TRIG, 16'h0);

    // R4 / R5 rising: falling edge ignored
    pin_at(4, 1'b1, 1'b1);
    pin_at(9, 1'b0, 1'b0);
    pin_at(9, 1'b1, 1'b1);
    settle();

    // R8 lock while running: only edge field changes -> both edges
    wr(A_MODE, 16'h0052);
    rd_chk("R8 mode locked", A_MODE, 16'h00A6);
    pin_at(6, 1'b0, 1'b1);   // R5 both edges
    pin_at(11, 1'b1, 1'b1);
    settle();

    // R5 falling only
    wr(A_MODE, 16'h0000);
    rd_chk("R5 mode falling", A_MODE, 16'h00A4);
    pin_at(7, 1'b0, 1'b1);
    pin_at(7, 1'b1, 1'b0);
    pin_at(7, 1'b0, 1'b1);
    settle();

    // R5 reserved code behaves as falling
    wr(A_MODE, 16'h0003);
    rd_chk("R5 mode reserved", A_MODE, 16'h00A7);
    pin_at(7, 1'b1, 1'b0);
    pin_at(7, 1'b0, 1'b1);
    settle();

    // R6 long interval wraps the counter
    pin_at(69990, 1'b1, 1'b0);
    pin_at(10, 1'b0, 1'b1);
    settle();

    // R7 stop: count held, overflow kept, no interrupts
    wr(A_TRIG, 16'h0002);
    rd_chk("R7 enable cleared", A_EN, 16'h0);
    rd(A_COUNT, c1);
    repeat (6) @(negedge clk);
    rd(A_COUNT, c2);
    check("R7 count held", c2, c1);
    rd_chk("R7 overflow kept", A_STAT, 16'h0001);
    n = irq_cnt;
    pin_at(5, 1'b1, 1'b0);
    pin_at(5, 1'b0, 1'b0);
    repeat (10) @(negedge clk);
    check("R7 no irq while stopped", 16'(irq_cnt), 16'(n));

    // R8 writable again when stopped: falling, start irq off, aux=5
    wr(A_MODE, 16'h0050);
    rd_chk("R8 mode rewritten", A_MODE, 16'h0050);

    // R3 restart without start interrupt
    n = irq_cnt;
    wr(A_TRIG, 16'h0001);
    anchor = cyc - 2;
    repeat (4) @(negedge clk);
    check("R3 no start irq", 16'(irq_cnt), 16'(n));
    pin_at(5, 1'b1, 1'b0);
    pin_at(6, 1'b0, 1'b1);   // R6 short interval clears the flag
    settle();

    // R10 no tick: counter frozen, edges not sampled
    tick = 1'b0;
    rd(A_COUNT, c1);
    repeat (10) @(negedge clk);
    rd(A_COUNT, c2);
    check("R10 count frozen", c2, c1);
    n = irq_cnt;
    pin_at(3, 1'b1, 1'b0);
    pin_at(3, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    tick = 1'b1;
    repeat (10) @(negedge clk);
    check("R10 edge between ticks ignored", 16'(irq_cnt), 16'(n));

    // R7 start and stop in one write resolve as stop
    n = irq_cnt;
    wr(A_TRIG, 16'h0003);
    rd_chk("R7 start+stop -> stopped", A_EN, 16'h0);
    repeat (5) @(negedge clk);
    check("R7 start+stop no irq", 16'(irq_cnt), 16'(n));

    // R9 unit disable clears state and blocks writes
    unit_en = 1'b0;
    repeat (2) @(negedge clk);
    wr(A_MODE, 16'h00F7);
    rd_chk("R9 mode write ignored", A_MODE, 16'h0);
    rd_chk("R9 capture cleared", A_CAPT, 16'h0);
    rd_chk("R9 count cleared", A_COUNT, 16'h0);
    unit_en = 1'b1;
    rd_chk("R9 mode still default", A_MODE, 16'h0);

    check("R4 all captures seen", 16'(q.size()), 16'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule